// File: doc/BRIEF.md
# Wide Register Block Access Unit

This unit connects a 32-bit memory-mapped slave port to one logical register that is wider than the bus word. The register is split into consecutive blocks. Each block covers `2^BLK_SIZE` bytes, and block `k` starts at `BASE_ADDR + k*2^BLK_SIZE`. The address bits below `BLK_SIZE` are not compared. Block `k` carries register bits `32k+31..32k`. The base only needs block alignment. The number of blocks does not have to be a power of two, and the register does not have to be aligned to its total size.

Reads and writes of the whole register are atomic through two holding registers, one for reads and one for writes. Each is as wide as the register minus one bus word.
- **Reads:** reading the first block samples the whole register once, returns the low word and keeps the rest. Reads of later blocks are served from the read holding register.
- **Writes:** writes to earlier blocks collect data and byte strobes in the write holding register. The write to the last block presents the full value and strobes on a parallel port in one cycle.

A privilege lockout, which can be switched off, rejects unprivileged transfers while a privileged multi-block sequence is open. The same switch enables clearing of the read holding register at the end of each read sequence.

Top module: `wide_reg_access`

## Requirements
- R1: An access hits block `k` when `addr >> BLK_SIZE` equals `(BASE_ADDR >> BLK_SIZE) + k`, whatever the ignored low bits are. An access that hits no block gets response code 2'b11, read data 0, and has no effect on the register port.
- R2: A read of block 0 raises `fld_rd_en` in the same cycle as the request. It answers one cycle later with code 2'b00 and register bits 31..0 as sampled in the request cycle.
- R3: A read of block `k>0` keeps `fld_rd_en` low and returns bits `32k+31..32k` as captured by the last block-0 read, even if the register has changed since.
- R4: Writes to any block except the last produce no `fld_wr_en`. A write to the last block raises `fld_wr_en` for one cycle, one cycle after the request. At that point `fld_wr_data` holds every block's data, and strobe bit `4k+i` holds byte lane `i` of block `k`.
- R5: Every request cycle produces `rsp_valid` exactly one cycle later, in any block order.
- R6: While a sequence opened with `prot[0]=1` is in progress (a read after block 0 until the last block, or a write after block 0 until the commit), a request with `prot[0]=0` is answered with code 2'b10 and read data 0. It raises no `fld_rd_en` and does not change either holding register.
- R7: When lockout is enabled, a read of the last block clears the read holding register. A later read of a middle block without a new block-0 read then returns 0.
- R8: After reset, `rsp_valid`, `fld_rd_en` and `fld_wr_en` are low, and both holding registers, sequence flags and stored privilege levels are cleared.
- R9: Once a privileged sequence completes, unprivileged requests are accepted again with code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane write strobes |
| req_prot | input | 3 | Protection bits; bit 0 = privileged |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_resp | output | 2 | 00 okay, 10 rejected, 11 no block hit |
| rsp_rdata | output | 32 | Read data |
| fld_rd_en | output | 1 | Whole-register read strobe |
| fld_rd_data | input | REG_W | Current register value |
| fld_wr_en | output | 1 | Whole-register commit pulse |
| fld_wr_data | output | REG_W | Committed value |
| fld_wr_strb | output | REG_W/8 | Committed byte strobes |

## Verification
The assertions check on every cycle that:
- each request is answered exactly one cycle later;
- a register read strobe only appears for an accepted read request;
- a commit only follows a write request and comes with an okay response;
- every non-okay response carries zero data;
- everything is idle after reset.

Holding-register contents, block slicing, strobe placement, lockout, and the clearing of the read holding register depend on whole access sequences. Only the bench's scenarios can show these, by comparing port values against values it computes itself.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_REJECT = 2'b10,
    RSP_NOHIT  = 2'b11
  } rsp_code_e;
endpackage

// File: rtl/wreg_blk_decode.sv
module wreg_blk_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0118,
  parameter int          BLK_SIZE  = 3,
  parameter int          NBLK      = 3,
  localparam int         IDX_W     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             is_first,
  output logic             is_last
);
  logic [NBLK-1:0] hits;
  logic [31:0]     addr_blk;

  assign addr_blk = addr >> BLK_SIZE;

  for (genvar k = 0; k < NBLK; k++) begin : g_match
    localparam logic [31:0] BLK_NUM = (BASE_ADDR >> BLK_SIZE) + 32'(k);
    assign hits[k] = (addr_blk == BLK_NUM);
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NBLK; k++) begin
      if (hits[k]) idx = IDX_W'(k);
    end
  end

  assign hit      = |hits;
  assign is_first = hits[0];
  assign is_last  = hits[NBLK-1];
endmodule

// File: rtl/wreg_rd_path.sv
module wreg_rd_path #(
  parameter int  REG_W    = 96,
  parameter bit  CLEAR_EN = 1'b1,
  localparam int NBLK     = REG_W / 32,
  localparam int IDX_W    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic [IDX_W-1:0] idx,
  input  logic             is_first,
  input  logic             is_last,
  input  logic [REG_W-1:0] fld_rdata,
  output logic [31:0]      word,
  output logic             busy
);
  logic [NBLK-2:0][31:0] hold_q;

  always_comb begin
    word = '0;
    if (is_first) begin
      word = fld_rdata[31:0];
    end else begin
      for (int k = 1; k < NBLK; k++) begin
        if (idx == IDX_W'(k)) word = hold_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      busy   <= 1'b0;
    end else if (rd_go && is_first) begin
      hold_q <= fld_rdata[REG_W-1:32];
      busy   <= 1'b1;
    end else if (rd_go && is_last) begin
      busy <= 1'b0;
      if (CLEAR_EN) hold_q <= '0;
    end
  end
endmodule

// File: rtl/wreg_wr_path.sv
module wreg_wr_path #(
  parameter int  REG_W = 96,
  localparam int NBLK  = REG_W / 32,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_go,
  input  logic [IDX_W-1:0]   idx,
  input  logic               is_last,
  input  logic [31:0]        wdata,
  input  logic [3:0]         wstrb,
  output logic               commit_en,
  output logic [REG_W-1:0]   commit_data,
  output logic [REG_W/8-1:0] commit_strb,
  output logic               busy
);
  logic [NBLK-2:0][31:0] dhold_q;
  logic [NBLK-2:0][3:0]  shold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dhold_q     <= '0;
      shold_q     <= '0;
      busy        <= 1'b0;
      commit_en   <= 1'b0;
      commit_data <= '0;
      commit_strb <= '0;
    end else begin
      commit_en <= 1'b0;
      if (wr_go && is_last) begin
        commit_en   <= 1'b1;
        commit_data <= {wdata, dhold_q};
        commit_strb <= {wstrb, shold_q};
        dhold_q     <= '0;
        shold_q     <= '0;
        busy        <= 1'b0;
      end else if (wr_go) begin
        for (int k = 0; k < NBLK - 1; k++) begin
          if (idx == IDX_W'(k)) begin
            dhold_q[k] <= wdata;
            shold_q[k] <= wstrb;
          end
        end
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wide_reg_access.sv
module wide_reg_access
  import wreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h0000_0118,
  parameter int          BLK_SIZE   = 3,
  parameter int          REG_W      = 96,
  parameter bit          LOCKOUT_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_wstrb,
  input  logic [2:0]         req_prot,
  output logic               rsp_valid,
  output logic [1:0]         rsp_resp,
  output logic [31:0]        rsp_rdata,
  output logic               fld_rd_en,
  input  logic [REG_W-1:0]   fld_rd_data,
  output logic               fld_wr_en,
  output logic [REG_W-1:0]   fld_wr_data,
  output logic [REG_W/8-1:0] fld_wr_strb
);
  localparam int NBLK  = REG_W / BUS_W;
  localparam int IDX_W = $clog2(NBLK);

  logic             hit, is_first, is_last;
  logic [IDX_W-1:0] idx;
  logic             rd_busy, wr_busy, rd_priv_q, wr_priv_q;
  logic             reject, accept, rd_go, wr_go;
  logic [31:0]      rd_word;
  logic [2:0]       prot_unused;

  assign prot_unused = req_prot;

  wreg_blk_decode #(
    .BASE_ADDR(BASE_ADDR), .BLK_SIZE(BLK_SIZE), .NBLK(NBLK)
  ) u_dec (
    .addr(req_addr), .hit(hit), .idx(idx),
    .is_first(is_first), .is_last(is_last)
  );

  assign reject = LOCKOUT_EN && !req_prot[0] &&
                  ((rd_busy && rd_priv_q) || (wr_busy && wr_priv_q));
  assign accept = req_valid && hit && !reject;
  assign rd_go  = accept && !req_write;
  assign wr_go  = accept && req_write;

  wreg_rd_path #(.REG_W(REG_W), .CLEAR_EN(LOCKOUT_EN)) u_rd (
    .clk(clk), .rst(rst), .rd_go(rd_go), .idx(idx),
    .is_first(is_first), .is_last(is_last),
    .fld_rdata(fld_rd_data), .word(rd_word), .busy(rd_busy)
  );

  wreg_wr_path #(.REG_W(REG_W)) u_wr (
    .clk(clk), .rst(rst), .wr_go(wr_go), .idx(idx), .is_last(is_last),
    .wdata(req_wdata), .wstrb(req_wstrb),
    .commit_en(fld_wr_en), .commit_data(fld_wr_data),
    .commit_strb(fld_wr_strb), .busy(wr_busy)
  );

  assign fld_rd_en = rd_go && is_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_priv_q <= 1'b0;
      wr_priv_q <= 1'b0;
    end else begin
      if (rd_go && is_first)     rd_priv_q <= req_prot[0];
      else if (rd_go && is_last) rd_priv_q <= 1'b0;
      if (wr_go && is_last)      wr_priv_q <= 1'b0;
      else if (wr_go && is_first) wr_priv_q <= req_prot[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_resp  <= RSP_OKAY;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_go ? rd_word : '0;
      if (!hit)        rsp_resp <= RSP_NOHIT;
      else if (reject) rsp_resp <= RSP_REJECT;
      else             rsp_resp <= RSP_OKAY;
    end
  end
endmodule

// File: rtl/wreg_chk.sv
module wreg_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic [1:0]  rsp_resp,
  input logic [31:0] rsp_rdata,
  input logic        fld_rd_en,
  input logic        fld_wr_en
);
  a_r5_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_rd_strobe_on_read: assert property (@(posedge clk) disable iff (rst)
    fld_rd_en |-> (req_valid && !req_write));
  a_r2_rd_strobe_okay: assert property (@(posedge clk) disable iff (rst)
    fld_rd_en |=> (rsp_valid && rsp_resp == 2'b00));
  a_r4_commit_after_write: assert property (@(posedge clk) disable iff (rst)
    fld_wr_en |-> (rsp_valid && rsp_resp == 2'b00 && rsp_rdata == '0));
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_resp != 2'b00) |-> (rsp_rdata == '0));
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !fld_wr_en));
endmodule

bind wide_reg_access wreg_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_resp(rsp_resp), .rsp_rdata(rsp_rdata),
  .fld_rd_en(fld_rd_en), .fld_wr_en(fld_wr_en)
);

// File: tb/tb_wide_reg_access.sv
module tb_wide_reg_access;
  localparam logic [31:0] BASE = 32'h0000_0118;
  localparam int          REGW = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_wstrb = '0;
  logic [2:0]  req_prot = '0;
  logic        rsp_valid, fld_rd_en, fld_wr_en;
  logic [1:0]  rsp_resp;
  logic [31:0] rsp_rdata;
  logic [REGW-1:0] fld_rd_data = '0, fld_wr_data;
  logic [REGW/8-1:0] fld_wr_strb;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Observed per request
  logic [31:0] o_rdata;
  logic [1:0]  o_resp;
  logic        o_rden, o_wren, o_rv;
  logic [REGW-1:0] o_wd;
  logic [REGW/8-1:0] o_ws;

  wide_reg_access dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .req_prot(req_prot), .rsp_valid(rsp_valid), .rsp_resp(rsp_resp),
    .rsp_rdata(rsp_rdata), .fld_rd_en(fld_rd_en), .fld_rd_data(fld_rd_data),
    .fld_wr_en(fld_wr_en), .fld_wr_data(fld_wr_data), .fld_wr_strb(fld_wr_strb)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] blk_addr(int k, bit off);
    return BASE + 32'(k * 8) + (off ? 32'd4 : 32'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the response.
  task automatic do_req(input bit w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p);
    req_valid = 1'b1; req_write = w; req_addr = a;
    req_wdata = d; req_wstrb = s; req_prot = p;
    #1 o_rden = fld_rd_en;
    @(posedge clk);
    @(negedge clk);
    o_rv = rsp_valid; o_resp = rsp_resp; o_rdata = rsp_rdata;
    o_wren = fld_wr_en; o_wd = fld_wr_data; o_ws = fld_wr_strb;
    req_valid = 1'b0;
  endtask

  task automatic read_seq(input logic [2:0] p);
    logic [REGW-1:0] v;
    v = {$urandom, $urandom, $urandom};
    fld_rd_data = v;
    for (int k = 0; k < 3; k++) begin
      do_req(1'b0, blk_addr(k, $urandom_range(0, 1) == 1), 32'h0, 4'h0, p);
      if (k == 0) fld_rd_data = ~v;  // register changes after capture
      chk(o_rv && o_resp == 2'b00, "R5 R2 read response", {o_rv, o_resp}, 3'b100);
      chk(o_rdata == v[k*32 +: 32], (k == 0) ? "R2 low word" : "R3 held slice",
          o_rdata, v[k*32 +: 32]);
      chk(o_rden == (k == 0), "R2 R3 read strobe", o_rden, (k == 0));
    end
  endtask

  task automatic write_seq(input logic [2:0] p);
    logic [REGW-1:0] d;
    logic [REGW/8-1:0] s;
    d = {$urandom, $urandom, $urandom};
    s = 12'($urandom);
    for (int k = 0; k < 3; k++) begin
      do_req(1'b1, blk_addr(k, $urandom_range(0, 1) == 1), d[k*32 +: 32],
             s[k*4 +: 4], p);
      chk(o_rv && o_resp == 2'b00, "R5 write response", {o_rv, o_resp}, 3'b100);
      chk(o_wren == (k == 2), "R4 commit only on last block", o_wren, (k == 2));
    end
    chk(o_wd == d, "R4 commit data", o_wd, d);
    chk(o_ws == s, "R4 commit strobes", o_ws, s);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [REGW-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!rsp_valid && !fld_wr_en && !fld_rd_en, "R8 reset outputs idle",
        {rsp_valid, fld_wr_en, fld_rd_en}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: holding register empty after reset
    do_req(1'b0, blk_addr(1, 1'b0), 0, 0, 3'b000);
    chk(o_rdata == 0 && o_resp == 2'b00, "R8 read hold cleared at reset",
        {o_resp, o_rdata}, 34'h0);

    // Random full sequences
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 1) read_seq(3'($urandom));
      else write_seq(3'($urandom));
    end

    // R1: misses
    do_req(1'b0, BASE - 32'd8, 0, 0, 3'b001);
    chk(o_resp == 2'b11 && o_rdata == 0 && !o_rden, "R1 below base",
        {o_resp, o_rdata, o_rden}, {2'b11, 33'h0});
    do_req(1'b1, BASE + 32'd24, 32'hFFFF_FFFF, 4'hF, 3'b001);
    chk(o_resp == 2'b11 && !o_wren, "R1 above last block", {o_resp, o_wren}, 3'b110);
    do_req(1'b0, 32'h0, 0, 0, 3'b000);
    chk(o_resp == 2'b11 && o_rv, "R1 R5 address zero", {o_rv, o_resp}, 3'b111);

    // R6/R7/R9: read lockout
    v = {$urandom, $urandom, $urandom};
    fld_rd_data = v;
    do_req(1'b0, blk_addr(0, 0), 0, 0, 3'b001);
    chk(o_rdata == v[31:0], "R2 privileged low word", o_rdata, v[31:0]);
    do_req(1'b0, blk_addr(1, 0), 0, 0, 3'b000);
    chk(o_resp == 2'b10 && o_rdata == 0, "R6 unprivileged read rejected",
        {o_resp, o_rdata}, {2'b10, 32'h0});
    do_req(1'b0, blk_addr(0, 0), 0, 0, 3'b010);
    chk(o_resp == 2'b10 && !o_rden, "R6 rejected block0 no strobe",
        {o_resp, o_rden}, 3'b100);
    do_req(1'b1, blk_addr(2, 0), 32'h1234_5678, 4'hF, 3'b000);
    chk(o_resp == 2'b10 && !o_wren, "R6 unprivileged write rejected",
        {o_resp, o_wren}, 3'b100);
    do_req(1'b0, blk_addr(1, 1), 0, 0, 3'b001);
    chk(o_rdata == v[63:32], "R6 hold intact after rejects", o_rdata, v[63:32]);
    do_req(1'b0, blk_addr(2, 0), 0, 0, 3'b001);
    chk(o_rdata == v[95:64], "R3 last slice", o_rdata, v[95:64]);
    do_req(1'b0, blk_addr(1, 0), 0, 0, 3'b000);
    chk(o_resp == 2'b00 && o_rdata == 0, "R7 R9 hold cleared, unlocked",
        {o_resp, o_rdata}, 34'h0);
    do_req(1'b0, blk_addr(2, 0), 0, 0, 3'b000);

    // R6: write lockout
    do_req(1'b1, blk_addr(0, 0), 32'hAAAA_0001, 4'h3, 3'b001);
    do_req(1'b0, blk_addr(0, 0), 0, 0, 3'b000);
    chk(o_resp == 2'b10 && !o_rden, "R6 read rejected during write seq",
        {o_resp, o_rden}, 3'b100);
    do_req(1'b1, blk_addr(1, 0), 32'h5555_5555, 4'hF, 3'b000);
    chk(o_resp == 2'b10, "R6 unprivileged middle write rejected", o_resp, 2'b10);
    do_req(1'b1, blk_addr(1, 0), 32'hBBBB_0002, 4'hC, 3'b001);
    do_req(1'b1, blk_addr(2, 0), 32'hCCCC_0003, 4'h1, 3'b001);
    chk(o_wren && o_wd == 96'hCCCC_0003_BBBB_0002_AAAA_0001,
        "R4 R6 commit ignores rejected data", o_wd, 96'hCCCC_0003_BBBB_0002_AAAA_0001);
    chk(o_ws == 12'h1C3, "R4 strobe placement", o_ws, 12'h1C3);
    do_req(1'b0, blk_addr(0, 0), 0, 0, 3'b000);
    chk(o_resp == 2'b00, "R9 unlocked after commit", o_resp, 2'b00);
    do_req(1'b0, blk_addr(1, 0), 0, 0, 3'b000);
    do_req(1'b0, blk_addr(2, 0), 0, 0, 3'b000);

    // R5: out-of-order block accesses still answered
    do_req(1'b1, blk_addr(2, 0), 32'h0, 4'h0, 3'b000);
    chk(o_rv, "R5 lone last-block write answered", o_rv, 1'b1);
    do_req(1'b0, blk_addr(2, 0), 0, 0, 3'b000);
    chk(o_rv && o_resp == 2'b00, "R5 lone last-block read answered",
        {o_rv, o_resp}, 3'b100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule